// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Controller

This block walks a frame buffer in memory and streams its contents, one 32-bit word at a time, towards a pixel formatter. Software programs the frame geometry and a pending base address through a small register port. When a frame starts, the pending base is copied into the active base. Panning or page flipping therefore takes effect only between frames, and a frame is never split across two buffers.

Word reads go to a simple request/acknowledge memory port. Each returned word is placed in a small FIFO that the formatter drains with a valid/ready pair. A new read is issued only when the FIFO has a free slot. Software stops the block by clearing the enable bit. The block then issues no further reads, but it stays in the running state until the outstanding read has returned and the FIFO is empty. A self-clearing flush bit discards all buffered data, including a word that is still in flight. Software sets it before changing the geometry, so that a new picture does not start with stale words.

Top module: `frame_fetch_ctrl`

## Requirements
- R1: After reset, `mem_req`, `pix_valid` and `running` are 0, and the active-base register (offset 0x30) reads 0.
- R2: The geometry register at offset 0x10 holds the line count in bits 31:16 and the pixels per line in bits 15:0. The control bit 2 selects 4 bytes per pixel (1) or 2 bytes per pixel (0). A line is ceil(pixels × bytes per pixel / 4) words long, and a frame is lines × words-per-line words long.
- R3: Read addresses start at the active base and rise by 4 for each word. After the last word of a frame, the next read goes to the active base of the new frame.
- R4: A write to the pending base (offset 0x20) does not change the active base during a frame. The pending base is copied into the active base at the frame boundary, and the active-base register always reads the base in use.
- R5: The control register answers at three offsets. 0x00 writes the value directly, 0x04 ORs the written bits in, and 0x08 clears the written bits. Bit 0 is enable, bit 2 is the pixel-size select, and bit 3 reads back `running`.
- R6: At most one read is outstanding. `mem_req` and `mem_addr` hold steady until `mem_ack`, and a read is issued only when the FIFO has a free slot.
- R7: While enable is 0, no new read is issued. `running` stays 1 until no read is outstanding and the FIFO is empty, and only then falls to 0.
- R8: Writing 1 to control bit 1 empties the FIFO and drops any word still in flight. The bit always reads back as 0.
- R9: Words leave on `pix_data` in the order their reads were acknowledged, and each word carries the data returned for its read.
- R10: Writes to the active-base offset (0x30) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the word being read |
| mem_ack | input | 1 | Read accepted; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | DATA_W | Read data |
| pix_valid | output | 1 | FIFO holds a word |
| pix_data | output | DATA_W | Oldest word in the FIFO |
| pix_ready | input | 1 | Formatter takes the word |
| running | output | 1 | Fetch engine active or still draining |
| frame_sync | output | 1 | Pulse in the cycle the pending base is latched as active |

## Verification
The assertions check the following on every cycle:
- the request/address hold until acknowledge;
- that the FIFO never accepts a word it has no room for, and is empty after a flush;
- that a request is raised only while enabled;
- that `running` cannot fall while words or a read remain;
- that the active base changes only on a frame event;
- that the control set alias behaves as described.

Other behaviours need whole scenarios and are left to the bench. These are:
- the exact frame length for each pixel size and geometry;
- the wrap of the address back to the base;
- that a pending-base write lands on the first word of the next frame and not before;
- the ordering of the data stream;
- that writes to the active-base register are ignored.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  localparam int REG_W = 32;
  localparam int CNT_W = 16;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_GEOM  = 8'h10;
  localparam logic [7:0] OFS_NEXT  = 8'h20;
  localparam logic [7:0] OFS_CUR   = 8'h30;
  localparam logic [7:0] ALIAS_SET = 8'h04;
  localparam logic [7:0] ALIAS_CLR = 8'h08;

  localparam int CB_EN    = 0;
  localparam int CB_FLUSH = 1;
  localparam int CB_WIDE  = 2;
  localparam int CB_RUN   = 3;

  // words in one line: wide pixels are one word each, narrow pixels pack two per word
  function automatic logic [CNT_W-1:0] words_per_line(input logic [CNT_W-1:0] pix,
                                                      input logic wide);
    return wide ? pix : ((pix >> 1) + {{(CNT_W-1){1'b0}}, pix[0]});
  endfunction
endpackage

// File: rtl/ffc_regs.sv
module ffc_regs
  import ffc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              running,
  input  logic [ADDR_W-1:0] cur_base,
  output logic              en,
  output logic              wide,
  output logic              flush,
  output logic [CNT_W-1:0]  pix_cnt,
  output logic [CNT_W-1:0]  line_cnt,
  output logic [ADDR_W-1:0] next_base
);
  logic [2:0]       ctrl_now, ctrl_new;
  logic [REG_W-1:0] geom_q;

  assign ctrl_now = {wide, 1'b0, en};

  always_comb begin
    ctrl_new = ctrl_now;
    if (wr) begin
      case (addr)
        OFS_CTRL:             ctrl_new = wdata[2:0];
        OFS_CTRL | ALIAS_SET: ctrl_new = ctrl_now | wdata[2:0];
        OFS_CTRL | ALIAS_CLR: ctrl_new = ctrl_now & ~wdata[2:0];
        default:              ctrl_new = ctrl_now;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      wide      <= 1'b0;
      flush     <= 1'b0;
      geom_q    <= '0;
      next_base <= '0;
    end else begin
      en    <= ctrl_new[CB_EN];
      wide  <= ctrl_new[CB_WIDE];
      flush <= ctrl_new[CB_FLUSH];
      if (wr && addr == OFS_GEOM) geom_q <= wdata;
      if (wr && addr == OFS_NEXT) next_base <= wdata[ADDR_W-1:0];
    end
  end

  assign line_cnt = geom_q[31:16];
  assign pix_cnt  = geom_q[15:0];

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[CB_EN]   = en;
        rdata[CB_WIDE] = wide;
        rdata[CB_RUN]  = running;
      end
      OFS_GEOM: rdata = geom_q;
      OFS_NEXT: rdata = REG_W'(next_base);
      OFS_CUR:  rdata = REG_W'(cur_base);
      default:  rdata = '0;
    endcase
  end

  // R5: the set alias ORs the enable bit in
  p_set_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == (OFS_CTRL | ALIAS_SET) && wdata[CB_EN]) |=> en);
endmodule

// File: rtl/ffc_fifo.sv
module ffc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         room
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign room    = (count < CNT_W'(DEPTH));
  assign do_push = push && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign dout    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  // R6: a word never arrives when there is no free slot
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |-> (count < CNT_W'(DEPTH)));
  // R8: a flush leaves the FIFO empty
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);
endmodule

// File: rtl/ffc_seq.sv
module ffc_seq
  import ffc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wide,
  input  logic              flush,
  input  logic [CNT_W-1:0]  pix_cnt,
  input  logic [CNT_W-1:0]  line_cnt,
  input  logic [ADDR_W-1:0] next_base,
  input  logic              fifo_room,
  input  logic              fifo_empty,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] cur_base,
  output logic              running,
  output logic              push,
  output logic              frame_evt
);
  logic [CNT_W-1:0] wpl, wcnt, lcnt;
  logic             drop_q;
  logic             accept, start, wrap, issue, stop_ok, last_word, last_line;

  assign wpl       = words_per_line(pix_cnt, wide);
  assign last_word = ({1'b0, wcnt} + 1'b1) >= {1'b0, wpl};
  assign last_line = ({1'b0, lcnt} + 1'b1) >= {1'b0, line_cnt};
  assign accept    = mem_req && mem_ack;
  assign start     = !running && en;
  assign wrap      = accept && last_word && last_line;
  assign frame_evt = start || wrap;
  assign issue     = running && en && !mem_req && !flush && fifo_room;
  assign stop_ok   = running && !en && !mem_req && fifo_empty;
  assign push      = accept && !drop_q && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      cur_base <= '0;
      wcnt     <= '0;
      lcnt     <= '0;
      drop_q   <= 1'b0;
    end else begin
      if (start) begin
        running  <= 1'b1;
        cur_base <= next_base;
        mem_addr <= next_base;
        wcnt     <= '0;
        lcnt     <= '0;
      end else if (stop_ok) begin
        running <= 1'b0;
      end

      if (issue)       mem_req <= 1'b1;
      else if (accept) mem_req <= 1'b0;

      if (accept) begin
        if (last_word) begin
          wcnt <= '0;
          if (last_line) begin
            lcnt     <= '0;
            mem_addr <= next_base;
            cur_base <= next_base;
          end else begin
            lcnt     <= lcnt + 1'b1;
            mem_addr <= mem_addr + ADDR_W'(4);
          end
        end else begin
          wcnt     <= wcnt + 1'b1;
          mem_addr <= mem_addr + ADDR_W'(4);
        end
      end

      if (flush && mem_req && !mem_ack) drop_q <= 1'b1;
      else if (accept)                  drop_q <= 1'b0;
    end
  end

  // R6: request and address hold until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R7: a request only starts while enabled
  p_req_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(en));
  // R7: running cannot fall while data remains
  p_run_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (!fifo_empty || mem_req)) |=> running);
  // R4: the active base moves only on a frame event
  p_base_at_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_base) |-> $past(frame_evt));
endmodule

// File: rtl/frame_fetch_ctrl.sv
module frame_fetch_ctrl
  import ffc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  input  logic              pix_ready,
  output logic              running,
  output logic              frame_sync
);
  logic              en, wide, flush, push, fifo_empty, fifo_room;
  logic [CNT_W-1:0]  pix_cnt, line_cnt;
  logic [ADDR_W-1:0] next_base, cur_base;

  ffc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .running(running), .cur_base(cur_base), .en(en),
    .wide(wide), .flush(flush), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .next_base(next_base)
  );

  ffc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .wide(wide), .flush(flush),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .next_base(next_base),
    .fifo_room(fifo_room), .fifo_empty(fifo_empty), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .cur_base(cur_base),
    .running(running), .push(push), .frame_evt(frame_sync)
  );

  ffc_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(flush), .push(push), .din(mem_rdata),
    .pop(pix_ready), .dout(pix_data), .empty(fifo_empty), .room(fifo_room)
  );

  assign pix_valid = !fifo_empty;
endmodule

// File: tb/frame_fetch_ctrl_test.sv
`timescale 1ns/100ps
module frame_fetch_ctrl_test;
  localparam logic [31:0] KEY = 32'hC0DE_0000;
  localparam int DEPTH = 4;
  // {base, pixels, lines, wide}
  localparam logic [63:0] VEC [4] = '{
    {32'h0000_1000, 16'd8, 8'd2, 8'd0},
    {32'h0000_2000, 16'd3, 8'd3, 8'd1},
    {32'h0000_3000, 16'd5, 8'd2, 8'd0},
    {32'h0000_0040, 16'd1, 8'd1, 8'd1}
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic pix_valid, pix_ready = 0, running, frame_sync;
  logic [31:0] pix_data;

  int tests = 0, fails = 0, cyc = 0;
  int acc_n = 0, pop_n = 0;
  logic [31:0] acc_log [512];
  logic [31:0] pop_log [512];

  frame_fetch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .running(running), .frame_sync(frame_sync)
  );

  always #2.5 clk = ~clk;

  // memory responder and stream monitor, mid-cycle
  always @(negedge clk) begin
    #1;
    if (!rst_n) mem_ack = 0;
    else begin
      if (pix_valid && pix_ready && pop_n < 512) begin
        pop_log[pop_n] = pix_data; pop_n++;
      end
      if (mem_req && !mem_ack && acc_n < 512) begin
        mem_ack = 1; mem_rdata = mem_addr ^ KEY;
        acc_log[acc_n] = mem_addr; acc_n++;
      end else mem_ack = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_acc(input int n);
    while (acc_n < n) @(negedge clk);
  endtask

  task automatic stop_drain();
    pix_ready = 1;
    wr(8'h08, 32'h1);
    while (running) @(negedge clk);
    cycles(2);
  endtask

  initial begin
    logic [31:0] d;
    int s, ps, f, wpl;
    bit ok;
    cycles(4);
    // R1 reset state
    check(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    check(pix_valid == 0, "R1 pix_valid", 32'(pix_valid), 0);
    check(running == 0, "R1 running", 32'(running), 0);
    rst_n = 1;
    rd(8'h30, d); check(d == 0, "R1 active base", d, 0);

    // R5 control aliases
    wr(8'h00, 32'h4); rd(8'h00, d); check(d == 32'h4, "R5 direct", d, 32'h4);
    wr(8'h08, 32'h4); rd(8'h00, d); check(d == 32'h0, "R5 clear alias", d, 0);
    wr(8'h04, 32'h4); rd(8'h00, d); check(d == 32'h4, "R5 set alias", d, 32'h4);
    wr(8'h04, 32'h2); rd(8'h00, d); check(d == 32'h4, "R8 flush bit reads 0", d, 32'h4);

    // R10 active base is read-only
    wr(8'h30, 32'hDEAD_0000); rd(8'h30, d); check(d == 0, "R10 write ignored", d, 0);

    // table walk: R2, R3, R9
    foreach (VEC[i]) begin
      stop_drain();
      wpl = VEC[i][0] ? int'(VEC[i][31:16]) : (int'(VEC[i][31:16]) + 1) / 2;
      f = wpl * int'(VEC[i][15:8]);
      wr(8'h10, {8'h00, VEC[i][15:8], VEC[i][31:16]});
      wr(8'h20, VEC[i][63:32]);
      s = acc_n; ps = pop_n;
      wr(8'h00, {29'd0, VEC[i][0], 2'b01});
      wait_acc(s + 2 * f);
      ok = 1;
      for (int k = 0; k < 2 * f; k++)
        if (acc_log[s + k] != VEC[i][63:32] + 32'(4 * (k % f))) ok = 0;
      check(ok, "R3 address sequence", acc_log[s + 1], VEC[i][63:32] + 32'(4 * (1 % f)));
      check(acc_log[s + f] == VEC[i][63:32], "R2 frame length wrap", acc_log[s + f], VEC[i][63:32]);
      cycles(6);
      ok = 1;
      for (int k = 0; k < f; k++)
        if (pop_log[ps + k] != (acc_log[s + k] ^ KEY)) ok = 0;
      check(ok, "R9 stream order", pop_log[ps], acc_log[s] ^ KEY);
    end

    // R4 pending base lands at the frame boundary
    stop_drain();
    wr(8'h10, {16'd2, 16'd4});
    wr(8'h20, 32'h100);
    s = acc_n;
    wr(8'h00, 32'h5);
    wait_acc(s + 3);
    wr(8'h20, 32'h800);
    rd(8'h30, d); check(d == 32'h100, "R4 base unchanged mid-frame", d, 32'h100);
    wait_acc(s + 12);
    check(acc_log[s + 7] == 32'h11C, "R4 last word old base", acc_log[s + 7], 32'h11C);
    check(acc_log[s + 8] == 32'h800, "R4 first word new base", acc_log[s + 8], 32'h800);
    check(acc_log[s + 9] == 32'h804, "R4 step in new frame", acc_log[s + 9], 32'h804);
    rd(8'h30, d); check(d == 32'h800, "R4 active base readback", d, 32'h800);

    // R6 back-pressure
    stop_drain();
    pix_ready = 0;
    wr(8'h10, {16'd4, 16'd16});
    wr(8'h20, 32'h5000);
    s = acc_n; ps = pop_n;
    wr(8'h00, 32'h5);
    cycles(40);
    check(acc_n - s == DEPTH, "R6 reads limited by FIFO", 32'(acc_n - s), DEPTH);
    check(mem_req == 0, "R6 no request when full", 32'(mem_req), 0);

    // R7 stop drains before running falls
    wr(8'h08, 32'h1);
    cycles(10);
    check(running == 1, "R7 running while FIFO holds data", 32'(running), 1);
    check(acc_n - s == DEPTH, "R7 no reads after disable", 32'(acc_n - s), DEPTH);
    pix_ready = 1;
    while (running) @(negedge clk);
    check(pop_n - ps == DEPTH, "R7 all words delivered", 32'(pop_n - ps), DEPTH);
    check(pop_log[ps + 3] == (32'h500C ^ KEY), "R9 drained order", pop_log[ps + 3], 32'h500C ^ KEY);

    // R8 flush discards buffered data
    pix_ready = 0;
    s = acc_n; ps = pop_n;
    wr(8'h04, 32'h1);
    wait_acc(s + DEPTH);
    cycles(10);
    wr(8'h08, 32'h1);
    cycles(3);
    check(running == 1, "R8 running before flush", 32'(running), 1);
    wr(8'h04, 32'h2);
    cycles(5);
    check(pix_valid == 0, "R8 FIFO emptied", 32'(pix_valid), 0);
    check(running == 0, "R8 run falls after flush", 32'(running), 0);
    check(pop_n == ps, "R8 nothing delivered", 32'(pop_n - ps), 0);
    rd(8'h00, d); check(d == 32'h4, "R8 control readback", d, 32'h4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule